// File: doc/BRIEF.md
# Snapshot capture buffer with readout

This block records a burst of 12-bit converter samples at the full sample clock into an on-chip store and later plays the burst back at one eighth of that rate. Capture is armed either by a register command or by an external fill strobe. In one-shot mode the burst always runs until the store is full, and then it is frozen. In free-running mode the store is written as a ring until the fill strobe stops it, so that it keeps the most recent samples.

A dump strobe starts playback. Playback begins with the oldest retained sample and ends when the store is empty. Each word is sent either as one 12-bit parallel word or as two 6-bit halves on a double-data-rate path. The output word can be recoded into offset binary, twos complement or Gray code on its way out. Two flags report whether the store is full and whether it is empty. The whole block runs on one clock, and a divide counter provides the readout rate enable.

Top module: `snap_capture_buf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, and neither `par_valid` nor `ddr_valid` is asserted.
- R2: With `mode_cont`=0 in the idle state, a pulse on `arm_cmd` or on `fill_strobe` starts a capture. The sample on the triggering edge is not stored. The next DEPTH samples, one per clock, are stored, and then writing stops by itself with `full`=1.
- R3: While a completed capture is held, further `arm_cmd` or `fill_strobe` pulses and the changing `sample_in` have no effect: `full` stays 1 and a later dump returns the originally captured burst.
- R4: With `mode_cont`=1, `arm_cmd` starts writing on every clock. The address wraps, so the oldest data is overwritten. A `fill_strobe` pulse stops writing, and the sample on that edge is not stored. A dump then returns the last min(N, DEPTH) of the N written samples, oldest first.
- R5: A `dump` pulse while a burst is held starts readout of every held word in order. A `dump` while the store is empty produces no output word.
- R6: The first output word appears 8 clocks after the edge that samples `dump`. Each later word follows exactly 8 clocks after the one before it.
- R7: With `ddr_sel`=0, each word is presented on `par_data` with `par_valid` high for one clock.
- R8: With `ddr_sel`=1, each word is sent over two consecutive clocks. The first clock carries bits 11:6 with `ddr_clk`=1, and the next clock carries bits 5:0 with `ddr_clk`=0. `ddr_valid` is high on both clocks.
- R9: Input samples are offset binary. The value of `fmt_sel` selects the output coding: 0 and 3 give offset binary unchanged, 1 gives twos complement (MSB inverted), and 2 gives Gray code w ^ (w >> 1).
- R10: `full` is 1 exactly when DEPTH words are held, and `empty` is 1 exactly when none are held. The two flags are never both high, and the count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cont | input | 1 | Capture mode: 0 one-shot, 1 free-running |
| arm_cmd | input | 1 | Register command pulse that starts a capture |
| fill_strobe | input | 1 | External strobe: starts a one-shot capture or stops a free-running one |
| dump | input | 1 | Starts readout of the held burst |
| fmt_sel | input | 2 | Output coding select |
| ddr_sel | input | 1 | 0 parallel port, 1 double-data-rate port |
| sample_in | input | 12 | Converter sample, offset binary |
| par_data | output | 12 | Parallel readout word |
| par_valid | output | 1 | Parallel word valid |
| ddr_data | output | 6 | Half-word on the double-data-rate path |
| ddr_valid | output | 1 | Half-word valid |
| ddr_clk | output | 1 | 1 on the upper half, 0 on the lower half |
| full | output | 1 | Store holds DEPTH words |
| empty | output | 1 | Store holds no word |

## Verification
A sample driven before the edge that triggers a capture is not stored. The stored samples are those presented on the following edges, and `full` is visible at the first sampling point after the last write. For readout, the bench counts falling-edge sampling points from the one after the edge that took `dump`. Parallel word j must show up at point 9+8j, and on the double-data-rate path its lower half must follow at the next point. Each word is compared both by value and by that exact position, so a late, early or doubled word is caught as well as a wrong one.

// File: rtl/snapbuf_pkg.sv
package snapbuf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CAPT = 2'd1,
      ST_HELD = 2'd2,
      ST_READ = 2'd3
   } snap_state_e;

   localparam logic [1:0] FMT_OFFBIN = 2'd0;
   localparam logic [1:0] FMT_TWOS   = 2'd1;
   localparam logic [1:0] FMT_GRAY   = 2'd2;

endpackage

// File: rtl/snap_mem.sv
module snap_mem #(
   parameter int DW    = 12,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
   import snapbuf_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int RD_DIV = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1,
   localparam int DVW   = $clog2(RD_DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_cont,
   input  logic          arm_cmd,
   input  logic          fill_strobe,
   input  logic          dump,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          full,
   output logic          empty
);

   localparam logic [CW-1:0]  CNT_MAX  = CW'(DEPTH);
   localparam logic [DVW-1:0] DIV_LAST = DVW'(RD_DIV - 1);

   snap_state_e    state;
   logic           cont_q;
   logic [AW-1:0]  wptr;
   logic [AW-1:0]  rptr;
   logic [CW-1:0]  cnt;
   logic [DVW-1:0] div;

   assign wr_en   = (state == ST_CAPT) && !(cont_q && fill_strobe);
   assign wr_addr = wptr;
   assign rd_en   = (state == ST_READ) && (div == DIV_LAST);
   assign rd_addr = rptr;
   assign full    = (cnt == CNT_MAX);
   assign empty   = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cont_q <= 1'b0;
         wptr   <= '0;
         rptr   <= '0;
         cnt    <= '0;
         div    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (arm_cmd || (fill_strobe && !mode_cont)) begin
                  state  <= ST_CAPT;
                  cont_q <= mode_cont;
                  wptr   <= '0;
                  cnt    <= '0;
               end
            end
            ST_CAPT: begin
               if (cont_q && fill_strobe) begin
                  state <= ST_HELD;
               end else begin
                  wptr <= wptr + 1'b1;
                  if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                  if (!cont_q && (cnt == CNT_MAX - 1'b1)) state <= ST_HELD;
               end
            end
            ST_HELD: begin
               if (dump) begin
                  // oldest retained word sits cnt entries behind the write pointer
                  rptr  <= wptr - cnt[AW-1:0];
                  div   <= '0;
                  state <= (cnt == '0) ? ST_IDLE : ST_READ;
               end
            end
            default: begin
               div <= (div == DIV_LAST) ? '0 : div + 1'b1;
               if (div == DIV_LAST) begin
                  rptr <= rptr + 1'b1;
                  cnt  <= cnt - 1'b1;
                  if (cnt == CW'(1)) state <= ST_IDLE;
               end
            end
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX); // R10
   AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en); // R6
   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HELD && !dump) |=> ($stable(cnt) && $stable(wptr))); // R3
   AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cont_q && cnt == CNT_MAX - 1'b1) |=> (full && !wr_en)); // R2

endmodule

// File: rtl/snap_out.sv
module snap_out
   import snapbuf_pkg::*;
#(
   parameter int DW  = 12,
   localparam int HW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [DW-1:0] rd_word,
   input  logic [1:0]    fmt_sel,
   input  logic          ddr_sel,
   output logic [DW-1:0] par_data,
   output logic          par_valid,
   output logic [HW-1:0] ddr_data,
   output logic          ddr_valid,
   output logic          ddr_clk
);

   logic [DW-1:0] gray_w;
   logic [DW-1:0] fw;
   logic [HW-1:0] lo_q;
   logic          lo_pend;

   for (genvar i = 0; i < DW; i++) begin : g_gray
      if (i == DW - 1) begin : g_top
         assign gray_w[i] = rd_word[i];
      end else begin : g_mid
         assign gray_w[i] = rd_word[i] ^ rd_word[i+1];
      end
   end

   always_comb begin
      case (fmt_sel)
         FMT_TWOS: fw = {~rd_word[DW-1], rd_word[DW-2:0]};
         FMT_GRAY: fw = gray_w;
         default:  fw = rd_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_data  <= '0;
         par_valid <= 1'b0;
         ddr_data  <= '0;
         ddr_valid <= 1'b0;
         ddr_clk   <= 1'b0;
         lo_q      <= '0;
         lo_pend   <= 1'b0;
      end else begin
         par_valid <= rd_en && !ddr_sel;
         if (rd_en && !ddr_sel) par_data <= fw;
         if (rd_en && ddr_sel) begin
            ddr_data  <= fw[DW-1:HW];
            lo_q      <= fw[HW-1:0];
            lo_pend   <= 1'b1;
            ddr_valid <= 1'b1;
            ddr_clk   <= 1'b1;
         end else if (lo_pend) begin
            ddr_data  <= lo_q;
            lo_pend   <= 1'b0;
            ddr_valid <= 1'b1;
            ddr_clk   <= 1'b0;
         end else begin
            ddr_valid <= 1'b0;
            ddr_clk   <= 1'b0;
         end
      end
   end

   AST_DDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (ddr_valid && ddr_clk) |=> (ddr_valid && !ddr_clk)); // R8
   AST_PAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      par_valid |=> !par_valid); // R7

endmodule

// File: rtl/snap_capture_buf.sv
module snap_capture_buf #(
   parameter int DW     = 12,
   parameter int DEPTH  = 1024,
   parameter int RD_DIV = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int HW    = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_cont,
   input  logic          arm_cmd,
   input  logic          fill_strobe,
   input  logic          dump,
   input  logic [1:0]    fmt_sel,
   input  logic          ddr_sel,
   input  logic [DW-1:0] sample_in,
   output logic [DW-1:0] par_data,
   output logic          par_valid,
   output logic [HW-1:0] ddr_data,
   output logic          ddr_valid,
   output logic          ddr_clk,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
      $error("DW must be even and at least 2");
   end
   if (RD_DIV < 2) begin : g_bad_div
      $error("RD_DIV must leave room for two half-words");
   end

   logic          wr_en;
   logic          rd_en;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_word;

   snap_ctrl #(.DEPTH(DEPTH), .RD_DIV(RD_DIV)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .arm_cmd(arm_cmd),
      .fill_strobe(fill_strobe), .dump(dump), .wr_en(wr_en), .wr_addr(wr_addr),
      .rd_en(rd_en), .rd_addr(rd_addr), .full(full), .empty(empty)
   );

   snap_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(sample_in),
      .rd_addr(rd_addr), .rd_data(rd_word)
   );

   snap_out #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_word(rd_word),
      .fmt_sel(fmt_sel), .ddr_sel(ddr_sel), .par_data(par_data),
      .par_valid(par_valid), .ddr_data(ddr_data), .ddr_valid(ddr_valid),
      .ddr_clk(ddr_clk)
   );

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R10

endmodule

// File: tb/sim_snap_capture_buf.sv
module sim_snap_capture_buf;

   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_cont = 1'b0, arm_cmd = 1'b0, fill_strobe = 1'b0, dump = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic        ddr_sel = 1'b0;
   logic [11:0] sample_in = '0;
   logic [11:0] par_data;
   logic        par_valid;
   logic [5:0]  ddr_data;
   logic        ddr_valid, ddr_clk, full, empty;

   int n_chk = 0;
   int n_fail = 0;
   logic [11:0] exp_q [$];

   always #4 clk = ~clk;

   snap_capture_buf #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .arm_cmd(arm_cmd),
      .fill_strobe(fill_strobe), .dump(dump), .fmt_sel(fmt_sel), .ddr_sel(ddr_sel),
      .sample_in(sample_in), .par_data(par_data), .par_valid(par_valid),
      .ddr_data(ddr_data), .ddr_valid(ddr_valid), .ddr_clk(ddr_clk),
      .full(full), .empty(empty)
   );

   function automatic logic [11:0] fmt_ref(logic [11:0] w, logic [1:0] sel);
      case (sel)
         2'd1:    return w ^ 12'h800;
         2'd2:    return w ^ (w >> 1);
         default: return w;
      endcase
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic push(logic [11:0] s);
      exp_q.push_back(s);
      if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
   endtask

   // R2 / R3: one-shot capture, then ignored triggers
   task automatic cap_single(bit by_fill, int extra);
      exp_q.delete();
      mode_cont = 1'b0;
      sample_in = 12'($urandom);
      if (by_fill) fill_strobe = 1'b1; else arm_cmd = 1'b1;
      tick();
      arm_cmd = 1'b0; fill_strobe = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         sample_in = 12'($urandom);
         push(sample_in);
         tick();
      end
      chk(full == 1'b1, "R2 full after burst", int'(full), 1);
      chk(empty == 1'b0, "R10 not empty when held", int'(empty), 0);
      for (int i = 0; i < extra; i++) begin
         sample_in = 12'($urandom);
         arm_cmd = 1'($urandom);
         fill_strobe = 1'($urandom);
         tick();
      end
      arm_cmd = 1'b0; fill_strobe = 1'b0;
      if (extra > 0) chk(full == 1'b1, "R3 full held after triggers", int'(full), 1);
   endtask

   // R4: free-running capture of n samples then stop
   task automatic cap_cont(int n);
      exp_q.delete();
      mode_cont = 1'b1;
      arm_cmd = 1'b1;
      tick();
      arm_cmd = 1'b0;
      for (int i = 0; i < n; i++) begin
         sample_in = 12'($urandom);
         push(sample_in);
         tick();
      end
      sample_in = 12'($urandom);
      fill_strobe = 1'b1;
      tick();
      fill_strobe = 1'b0;
      chk(full == (n >= DEPTH), "R4 full after stop", int'(full), int'(n >= DEPTH));
   endtask

   // R5..R9: readout with value and position checks
   task automatic readout(bit ddr, logic [1:0] fmt);
      int idx = 0;
      int n = exp_q.size();
      logic [11:0] e;
      ddr_sel = ddr; fmt_sel = fmt;
      dump = 1'b1;
      tick();
      dump = 1'b0;
      for (int k = 1; k <= n * 8 + 12; k++) begin
         if (idx < n) e = fmt_ref(exp_q[idx], fmt);
         else e = '0;
         if (!ddr && par_valid) begin
            chk(idx < n, "R5 no extra word", idx, n - 1);
            chk(k == 9 + 8 * idx, "R6 word position", k, 9 + 8 * idx);
            chk(par_data == e, "R7 R9 parallel word", int'(par_data), int'(e));
            idx++;
         end
         if (ddr && ddr_valid && ddr_clk) begin
            chk(k == 9 + 8 * idx, "R6 half-word position", k, 9 + 8 * idx);
            chk(ddr_data == e[11:6], "R8 R9 upper half", int'(ddr_data), int'(e[11:6]));
         end
         if (ddr && ddr_valid && !ddr_clk) begin
            chk(k == 10 + 8 * idx, "R8 lower half position", k, 10 + 8 * idx);
            chk(ddr_data == e[5:0], "R8 R9 lower half", int'(ddr_data), int'(e[5:0]));
            idx++;
         end
         tick();
      end
      chk(idx == n, "R5 word count", idx, n);
      chk(empty == 1'b1 && full == 1'b0, "R10 empty after readout", int'(empty), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) tick();
      // R1 reset state
      chk(empty == 1'b1, "R1 empty at reset", int'(empty), 1);
      chk(full == 1'b0, "R1 full at reset", int'(full), 0);
      chk(!par_valid && !ddr_valid, "R1 no valid at reset", int'(par_valid), 0);
      rst_n = 1'b1;
      tick();

      // R5: dump with nothing held yields nothing
      exp_q.delete();
      readout(1'b0, 2'd0);

      cap_single(1'b0, 0);   readout(1'b0, 2'd0);
      cap_single(1'b1, 20);  readout(1'b1, 2'd2);
      cap_single(1'b0, 9);   readout(1'b0, 2'd1);
      cap_cont(DEPTH + 5);   readout(1'b0, 2'd3);
      cap_cont(7);           readout(1'b1, 2'd1);
      cap_cont(3 * DEPTH);   readout(1'b1, 2'd0);

      for (int r = 0; r < 8; r++) begin
         if (($urandom % 2) == 0) cap_single(1'($urandom), int'($urandom % 12));
         else cap_cont(1 + int'($urandom % 40));
         readout(1'($urandom), 2'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule